// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen architectural registers and the status registers of a 32-bit processor core, and decides which physical storage cell stands behind each register name in the current operating mode. Two combinational read ports and one write port take a 4-bit register index. A separate link-write strobe copies the program counter into register 14 of the active bank.

The operating mode is not a separate pin. It is the 5-bit mode field, bits [4:0], of the current status register, which is written through its own port. Bit 5 of that register selects the instruction state: 0 for wide 32-bit instructions, 1 for compressed 16-bit instructions. Register 15 is the program counter. It is read back with the low bits forced to zero as the instruction state requires. Decode, arithmetic, exception sequencing and memory access belong to the surrounding pipeline. The pipeline drives the ports of this block and sees only the resolved register contents.

Mode encodings: user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Any other 5-bit value behaves like user mode.

Top module: `bank_regfile`

## Requirements
- R1: During reset (rst_n low at a clock edge), the program counter becomes zero and the status register becomes 0x00000013. That value means supervisor mode and the wide instruction state. Other register contents are undefined after reset.
- R2: Indices 0 to 7 name one physical register each, shared by every mode. A value written in one mode reads back in any other mode.
- R3: User mode, system mode and every unlisted mode encoding share one set for indices 8 to 14.
- R4: In FIQ mode (10001), indices 8 to 14 select seven private registers that no other mode can see.
- R5: In supervisor, abort, IRQ and undefined modes, indices 13 and 14 select a private pair for that mode. Indices 8 to 12 select the user copies.
- R6: Index 15 is one shared program counter, and a write to index 15 updates it. It reads back, on both read ports and on pc_q, with bits [1:0] zero when status bit 5 is 0 and with bit 0 zero when status bit 5 is 1.
- R7: With link_en high, register 14 of the current bank receives the program counter as read (aligned) before that edge. If a write to index 14 arrives in the same cycle, the link write wins.
- R8: A write takes effect at the clock edge. A read of the register being written in the same cycle returns the old value. With no writes and no status write, a read of an unchanged index returns the same value.
- R9: The current status register is a single register. It reads back exactly the last value written by cpsr_we, and its bits [4:0] select the bank.
- R10: FIQ, supervisor, abort, IRQ and undefined modes each own one saved status register. spsr_q shows the one belonging to the current mode, and spsr_we writes only that one.
- R11: In user, system or any unlisted mode, spsr_q reads zero and spsr_we changes no saved status register.
- R12: In a cycle that also writes the status register, register writes, link writes and saved status writes use the mode in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | 32 | Read port A data, combinational |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| link_en | input | 1 | Copy the aligned program counter into register 14 of the current bank |
| cpsr_we | input | 1 | Current status register write strobe |
| cpsr_wdata | input | 32 | Current status register write data |
| spsr_we | input | 1 | Saved status register write strobe for the current mode |
| spsr_wdata | input | 32 | Saved status register write data |
| pc_q | output | 32 | Aligned program counter |
| cpsr_q | output | 32 | Current status register |
| spsr_q | output | 32 | Saved status register of the current mode, zero if the mode has none |

## Verification
The link copy and an ordinary register write can target register 14 in the same cycle. A status write that switches the mode can also coincide with a register write. The bench provokes both on purpose. In one cycle it raises link_en together with a write to index 14 (and elsewhere with a write to index 15). In another cycle it switches modes while writing register 13. It then reads the affected banks back in later cycles. In random traffic, coincidences of all four write paths occur often. A behavioural model keyed by register name resolves each coincidence from the rules, using the pre-edge mode and pre-edge program counter, and checks both read ports, the program counter and both status outputs on every cycle.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
// bank_pkg: shared constants, mode encodings and the mode-to-slot decode
// for the banked register file. Assumes a 5-bit mode field in status bits
// [4:0] and the instruction-state flag in status bit 5.
package bank_pkg;

    typedef enum logic [4:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    localparam int MODE_W        = 5;
    localparam int STATE_BIT     = 5;
    localparam int IDX_W         = 4;
    localparam int PC_IDX        = 15;
    localparam int LINK_IDX      = 14;
    localparam int STACK_IDX     = 13;
    localparam int FIRST_FIQ_IDX = 8;

    // Physical layout: user-visible 0..14, then the FIQ set, then the pairs.
    localparam int USER_REGS  = PC_IDX;
    localparam int FIQ_BASE   = USER_REGS;
    localparam int FIQ_COUNT  = PC_IDX - FIRST_FIQ_IDX;
    localparam int PAIR_BASE  = FIQ_BASE + FIQ_COUNT;
    localparam int PAIR_MODES = 4;
    localparam int PAIR_SIZE  = PC_IDX - STACK_IDX;
    localparam int PHYS_REGS  = PAIR_BASE + PAIR_MODES * PAIR_SIZE;
    localparam int PHYS_W     = $clog2(PHYS_REGS);

    // Saved status slots: one per exception mode.
    localparam int          NUM_SAVED = 1 + PAIR_MODES;
    localparam int          SLOT_W    = 3;
    localparam logic [2:0]  FIQ_SLOT  = 3'd0;
    localparam logic [2:0]  NO_SLOT   = 3'd7;

    // Map a mode field to its exception slot, or NO_SLOT for unbanked modes.
    function automatic logic [SLOT_W-1:0] saved_slot(input logic [MODE_W-1:0] m);
        case (m)
            MD_FIQ:  return 3'd0;
            MD_SVC:  return 3'd1;
            MD_ABT:  return 3'd2;
            MD_IRQ:  return 3'd3;
            MD_UND:  return 3'd4;
            default: return NO_SLOT;
        endcase
    endfunction

endpackage

// File: rtl/bank_name_map.sv
`timescale 1ns/1ps
// bank_name_map: resolves an architectural register index plus the current
// mode field into a physical storage index. Purely combinational.
// Assumes index 15 is handled outside the array (is_pc flags it); the
// phys_idx produced for index 15 is meaningless and must be ignored.
module bank_name_map
    import bank_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [IDX_W-1:0]  arch_idx,
    output logic [PHYS_W-1:0] phys_idx,
    output logic              is_pc
);

    logic [SLOT_W-1:0] slot;

    // Decode the exception slot once; it picks FIQ set or a private pair.
    always_comb slot = saved_slot(mode);

    // Default to the shared copy, then redirect banked names.
    always_comb begin
        is_pc    = (arch_idx == IDX_W'(PC_IDX));
        phys_idx = PHYS_W'(arch_idx);
        if (!is_pc && arch_idx >= IDX_W'(FIRST_FIQ_IDX)) begin
            if (slot == FIQ_SLOT) begin
                phys_idx = PHYS_W'(FIQ_BASE)
                         + PHYS_W'(arch_idx - IDX_W'(FIRST_FIQ_IDX));
            end else if (slot != NO_SLOT && arch_idx >= IDX_W'(STACK_IDX)) begin
                phys_idx = PHYS_W'(PAIR_BASE)
                         + PHYS_W'({slot - 3'd1, 1'b0})
                         + PHYS_W'(arch_idx - IDX_W'(STACK_IDX));
            end
        end
    end

endmodule

// File: rtl/bank_gpr_store.sv
`timescale 1ns/1ps
// bank_gpr_store: physical general register array, the program counter,
// two read ports, one write port and the link write into register 14.
// Assumes the mode and instruction state are stable for the whole cycle;
// writes use the mode present before the clock edge. No read bypass.
module bank_gpr_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              narrow,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] pc_view
);

    localparam int NUM_RD  = 2;
    localparam int P_WR    = NUM_RD;
    localparam int P_LINK  = NUM_RD + 1;
    localparam int NUM_MAP = NUM_RD + 2;

    logic [DATA_W-1:0] mem [PHYS_REGS];
    logic [DATA_W-1:0] pc_raw;
    logic [IDX_W-1:0]  port_idx  [NUM_MAP];
    logic [PHYS_W-1:0] port_phys [NUM_MAP];
    logic              port_pc   [NUM_MAP];
    logic [DATA_W-1:0] rd_data   [NUM_RD];

    // Gather the indices that need name resolution.
    always_comb begin
        port_idx[0]      = ra_idx;
        port_idx[1]      = rb_idx;
        port_idx[P_WR]   = wr_idx;
        port_idx[P_LINK] = IDX_W'(LINK_IDX);
    end

    // One name-mapping stage per port.
    for (genvar g = 0; g < NUM_MAP; g++) begin : g_map
        bank_name_map u_map (
            .mode     (mode),
            .arch_idx (port_idx[g]),
            .phys_idx (port_phys[g]),
            .is_pc    (port_pc[g])
        );
    end

    // Force the low program counter bits to zero for the active state.
    always_comb begin
        if (narrow) pc_view = {pc_raw[DATA_W-1:1], 1'b0};
        else        pc_view = {pc_raw[DATA_W-1:2], 2'b00};
    end

    // Read ports: program counter or resolved array cell.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_data[g] = port_pc[g] ? pc_view : mem[port_phys[g]];
    end
    assign ra_data = rd_data[0];
    assign rb_data = rd_data[1];

    // Array update; the link write is placed last so it overrides.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (wr_en && !port_pc[P_WR])
                mem[port_phys[P_WR]] <= wr_data;
            if (link_en && !port_pc[P_LINK])
                mem[port_phys[P_LINK]] <= pc_view;
        end
    end

    // Program counter register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_raw <= '0;
        else if (wr_en && port_pc[P_WR])
            pc_raw <= wr_data;
    end

endmodule

// File: rtl/bank_psr_store.sv
`timescale 1ns/1ps
// bank_psr_store: the current status register and one saved status register
// per exception mode. The saved register visible and writable is the one of
// the mode in the current status register before the edge.
// Assumes reset only needs to set the current status register.
module bank_psr_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpsr_we,
    input  logic [DATA_W-1:0] cpsr_wdata,
    input  logic              spsr_we,
    input  logic [DATA_W-1:0] spsr_wdata,
    output logic [DATA_W-1:0] cpsr_q,
    output logic [DATA_W-1:0] spsr_q
);

    localparam logic [DATA_W-1:0] RESET_STATUS = DATA_W'(MD_SVC);

    logic [DATA_W-1:0] saved [NUM_SAVED];
    logic [SLOT_W-1:0] slot;

    // Decode the slot of the current mode.
    always_comb slot = saved_slot(cpsr_q[MODE_W-1:0]);

    // Current status register with reset into supervisor, wide state.
    always_ff @(posedge clk) begin
        if (!rst_n)      cpsr_q <= RESET_STATUS;
        else if (cpsr_we) cpsr_q <= cpsr_wdata;
    end

    // Saved status registers; a write lands only in the current slot.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SAVED; s++) begin
            if (rst_n && spsr_we && slot == SLOT_W'(s))
                saved[s] <= spsr_wdata;
        end
    end

    // Present the current slot, zero for unbanked modes.
    always_comb begin
        spsr_q = '0;
        for (int s = 0; s < NUM_SAVED; s++) begin
            if (slot == SLOT_W'(s)) spsr_q = saved[s];
        end
    end

endmodule

// File: rtl/bank_regfile.sv
`timescale 1ns/1ps
// bank_regfile: top of the mode-banked register file. The mode and the
// instruction state come from the current status register; the general
// store resolves names and holds the program counter.
// Assumes DATA_W >= 8 so the mode field and state bit fit.
module bank_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [3:0]        rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic              cpsr_we,
    input  logic [DATA_W-1:0] cpsr_wdata,
    input  logic              spsr_we,
    input  logic [DATA_W-1:0] spsr_wdata,
    output logic [DATA_W-1:0] pc_q,
    output logic [DATA_W-1:0] cpsr_q,
    output logic [DATA_W-1:0] spsr_q
);

    logic [MODE_W-1:0] cur_mode;
    logic              cur_narrow;

    // Split the status register into the fields the store needs.
    always_comb begin
        cur_mode   = cpsr_q[MODE_W-1:0];
        cur_narrow = cpsr_q[STATE_BIT];
    end

    bank_psr_store #(.DATA_W(DATA_W)) u_psr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpsr_we    (cpsr_we),
        .cpsr_wdata (cpsr_wdata),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .cpsr_q     (cpsr_q),
        .spsr_q     (spsr_q)
    );

    bank_gpr_store #(.DATA_W(DATA_W)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cur_mode),
        .narrow  (cur_narrow),
        .ra_idx  (ra_idx),
        .rb_idx  (rb_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .link_en (link_en),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .pc_view (pc_q)
    );

endmodule

// File: rtl/bank_regfile_chk.sv
`timescale 1ns/1ps
// bank_regfile_chk: port-level properties of the banked register file,
// attached to every bank_regfile instance by the bind below.
module bank_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        ra_idx,
    input logic [DATA_W-1:0] ra_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_en,
    input logic              cpsr_we,
    input logic              spsr_we,
    input logic [DATA_W-1:0] spsr_wdata,
    input logic [DATA_W-1:0] pc_q,
    input logic [5:0]        stat_lo,
    input logic [DATA_W-1:0] spsr_q
);

    logic unbanked;
    always_comb unbanked = !(stat_lo[4:0] == 5'b10001 || stat_lo[4:0] == 5'b10011 ||
                             stat_lo[4:0] == 5'b10111 || stat_lo[4:0] == 5'b10010 ||
                             stat_lo[4:0] == 5'b11011);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && stat_lo == 6'b010011));

    assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < 4'd8) |=> (ra_idx != $past(wr_idx) || ra_data == $past(wr_data)));

    assert_pc_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[0] == 1'b0 && (stat_lo[5] || pc_q[1] == 1'b0));

    assert_pc_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == 4'd15) |-> (ra_data == pc_q));

    assert_link_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && !cpsr_we) |=> (ra_idx != 4'd14 || ra_data == $past(pc_q)));

    assert_hold_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !link_en && !cpsr_we) |=> (ra_idx != $past(ra_idx) || $stable(ra_data)));

    assert_saved_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_we && !cpsr_we && !unbanked) |=> (spsr_q == $past(spsr_wdata)));

    assert_saved_hidden_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unbanked |-> (spsr_q == '0));

endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra_idx     (ra_idx),
    .ra_data    (ra_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .link_en    (link_en),
    .cpsr_we    (cpsr_we),
    .spsr_we    (spsr_we),
    .spsr_wdata (spsr_wdata),
    .pc_q       (pc_q),
    .stat_lo    (cpsr_q[5:0]),
    .spsr_q     (spsr_q)
);

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
// sim_bank_regfile: name-keyed behavioural model compared on every cycle,
// plus directed sequences for the coincidence cases.
module sim_bank_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic        wr_en = 1'b0, link_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
    logic [31:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0;
    logic [31:0] ra_data, rb_data, pc_q, cpsr_q, spsr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] gm [string];
    logic [31:0] sm [string];
    logic [31:0] m_pc;
    logic [31:0] m_cpsr;

    always #2.5 clk = ~clk;

    bank_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .link_en(link_en),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
        .pc_q(pc_q), .cpsr_q(cpsr_q), .spsr_q(spsr_q)
    );

    function automatic bit exc_mode(input logic [4:0] m);
        return m == 5'b10001 || m == 5'b10011 || m == 5'b10111 ||
               m == 5'b10010 || m == 5'b11011;
    endfunction

    function automatic string loc(input logic [4:0] m, input int i);
        if (i < 8) return $sformatf("low%0d", i);
        if (m == 5'b10001) return $sformatf("fiq%0d", i);
        if (exc_mode(m) && i >= 13) return $sformatf("pair%0d_%0d", m, i);
        return $sformatf("usr%0d", i);
    endfunction

    function automatic string tag(input logic [4:0] m, input int i);
        if (i < 8) return "R2";
        if (i == 15) return "R6";
        if (m == 5'b10001) return "R4";
        if (exc_mode(m)) return "R5";
        return "R3";
    endfunction

    function automatic logic [31:0] align(input logic [31:0] p, input logic t);
        return t ? {p[31:1], 1'b0} : {p[31:2], 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FIL%s %s %s actual=%h expected=%h", "", req, what, act, exp);
        end
    endtask

    task automatic cmp_port(input logic [3:0] idx, input logic [31:0] act, input string nm);
        logic [4:0] m;
        string k;
        m = m_cpsr[4:0];
        if (idx == 4'd15) begin
            check(act == align(m_pc, m_cpsr[5]), "R6", nm, act, align(m_pc, m_cpsr[5]));
        end else begin
            k = loc(m, int'(idx));
            if (gm.exists(k)) check(act == gm[k], tag(m, int'(idx)), nm, act, gm[k]);
        end
    endtask

    task automatic compare_all();
        logic [4:0] m;
        string k;
        if (!rst_n) return;
        m = m_cpsr[4:0];
        cmp_port(ra_idx, ra_data, "read A");
        cmp_port(rb_idx, rb_data, "read B");
        check(pc_q == align(m_pc, m_cpsr[5]), "R6", "pc_q", pc_q, align(m_pc, m_cpsr[5]));
        check(cpsr_q == m_cpsr, "R9", "cpsr_q", cpsr_q, m_cpsr);
        if (exc_mode(m)) begin
            k = $sformatf("sp%0d", m);
            if (sm.exists(k)) check(spsr_q == sm[k], "R10", "spsr_q", spsr_q, sm[k]);
        end else begin
            check(spsr_q == 32'h0, "R11", "spsr_q", spsr_q, 32'h0);
        end
    endtask

    task automatic model_update();
        logic [4:0]  m;
        logic [31:0] pcv;
        if (!rst_n) begin
            gm.delete();
            sm.delete();
            m_pc = 32'h0;
            m_cpsr = 32'h0000_0013;
            return;
        end
        m = m_cpsr[4:0];
        pcv = align(m_pc, m_cpsr[5]);
        if (wr_en) begin
            if (wr_idx == 4'd15) m_pc = wr_data;
            else gm[loc(m, int'(wr_idx))] = wr_data;
        end
        if (link_en) gm[loc(m, 14)] = pcv;
        if (spsr_we && exc_mode(m)) sm[$sformatf("sp%0d", m)] = spsr_wdata;
        if (cpsr_we) m_cpsr = cpsr_wdata;
    endtask

    // One clock: compare before the edge, update the model after it.
    task automatic cyc();
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; link_en = 1'b0; cpsr_we = 1'b0; spsr_we = 1'b0;
    endtask

    task automatic set_status(input logic [31:0] v);
        idle(); cpsr_we = 1'b1; cpsr_wdata = v; cyc(); idle();
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        idle(); wr_en = 1'b1; wr_idx = 4'(i); wr_data = d; cyc(); idle();
    endtask

    task automatic expect_ra(input int i, input logic [31:0] exp, input string req);
        idle();
        ra_idx = 4'(i);
        #1;
        check(ra_data == exp, req, $sformatf("r%0d", i), ra_data, exp);
        cyc();
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pc = 32'h0;
        m_cpsr = 32'h0000_0013;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin @(posedge clk); model_update(); @(negedge clk); end
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(pc_q == 32'h0, "R1", "pc_q after reset", pc_q, 32'h0);
        check(cpsr_q == 32'h13, "R1", "cpsr_q after reset", cpsr_q, 32'h13);
        cyc();

        // R2/R3/R5: fill user set, then view from supervisor and system
        set_status(32'h10);
        for (int i = 0; i < 15; i++) wr(i, 32'h1000_0000 + i);
        set_status(32'h13);
        wr(13, 32'h5555_0013);
        expect_ra(8, 32'h1000_0008, "R5");
        expect_ra(13, 32'h5555_0013, "R5");
        expect_ra(3, 32'h1000_0003, "R2");
        set_status(32'h1F);
        expect_ra(13, 32'h1000_000D, "R3");
        set_status(32'h14);
        expect_ra(12, 32'h1000_000C, "R3");

        // R4: FIQ private set
        set_status(32'h11);
        wr(8, 32'hF1F0_0008);
        wr(5, 32'hF1F0_0005);
        expect_ra(8, 32'hF1F0_0008, "R4");
        set_status(32'h10);
        expect_ra(8, 32'h1000_0008, "R4");
        expect_ra(5, 32'hF1F0_0005, "R2");

        // R6: program counter alignment in both states
        wr(15, 32'h0000_1237);
        #1; check(pc_q == 32'h0000_1234, "R6", "pc_q wide", pc_q, 32'h0000_1234);
        set_status(32'h30);
        #1; check(pc_q == 32'h0000_1236, "R6", "pc_q narrow", pc_q, 32'h0000_1236);
        set_status(32'h11);
        expect_ra(15, 32'h0000_1234, "R6");

        // R7/R8: link and write to r14 in the same cycle; old value read
        set_status(32'h13);
        wr(14, 32'h0000_0055);
        idle();
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hDEAD_BEEF; link_en = 1'b1;
        ra_idx = 4'd14;
        #1; check(ra_data == 32'h0000_0055, "R8", "r14 during write", ra_data, 32'h55);
        cyc();
        expect_ra(14, 32'h0000_1234, "R7");
        idle();
        link_en = 1'b1; wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_2000;
        cyc();
        expect_ra(14, 32'h0000_1234, "R7");

        // R12: mode switch and r13 write in one cycle use the old bank
        idle();
        cpsr_we = 1'b1; cpsr_wdata = 32'h11;
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h0000_7777;
        cyc();
        set_status(32'h13);
        expect_ra(13, 32'h0000_7777, "R12");

        // R10/R11: saved status per mode, hidden in user
        idle(); spsr_we = 1'b1; spsr_wdata = 32'h0000_0ABC; cyc();
        set_status(32'h12);
        idle(); spsr_we = 1'b1; spsr_wdata = 32'h0000_0123; cyc();
        set_status(32'h10);
        idle(); spsr_we = 1'b1; spsr_wdata = 32'h0000_0999; cyc();
        #1; check(spsr_q == 32'h0, "R11", "spsr_q user", spsr_q, 32'h0);
        set_status(32'h13);
        #1; check(spsr_q == 32'h0000_0ABC, "R10", "spsr_q svc", spsr_q, 32'h0ABC);
        set_status(32'h12);
        #1; check(spsr_q == 32'h0000_0123, "R11", "irq slot untouched", spsr_q, 32'h0123);
        set_status(32'hABC0_0017);
        #1; check(cpsr_q == 32'hABC0_0017, "R9", "cpsr_q", cpsr_q, 32'hABC0_0017);

        // Random traffic across all modes, compared every cycle.
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] modes [9];
            modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                      5'b11011, 5'b11111, 5'b00000, 5'b10100};
            idle();
            ra_idx = 4'($urandom_range(0, 15));
            rb_idx = 4'($urandom_range(0, 15));
            wr_en = ($urandom_range(0, 1) == 0);
            wr_idx = 4'($urandom_range(0, 15));
            wr_data = $urandom;
            link_en = ($urandom_range(0, 5) == 0);
            spsr_we = ($urandom_range(0, 3) == 0);
            spsr_wdata = $urandom;
            cpsr_we = ($urandom_range(0, 7) == 0);
            cpsr_wdata = {$urandom_range(0, 65535), 10'h0, 1'($urandom_range(0, 1)),
                          modes[$urandom_range(0, 8)]};
            cyc();
        end
        idle();
        cyc();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule